// File: doc/BRIEF.md
# Field-Start Latency Comparator

This block sits at the receiver, where a video byte stream comes in over a slow path with high latency and a field marker comes in over a fast electrical path. It finds the start of each odd or even field in the byte stream and takes the matching marker from the control input. It then counts the receiver clock cycles between the two events. The signed count goes to a downstream delay stage. That stage holds back the faster path by a whole number of cycles, so the fast path needs no buffer of its own.

In the data stream, a field start is a timing reference code. This code is the three bytes FF, 00, 00 followed by a status byte whose field bit has changed since the previous such code. The counter starts on whichever event comes first and stops on the other. A result is published only when both events carry the same field parity. If the second event is late, the result is a timeout flag and the last good delay is left unchanged.

Top module: `field_skew_meter`

## Requirements
- R1: A synchronous active-high reset clears `skew_valid`, `timeout` and `skew_value` (to 0), returns the block to idle and sets the tracked field bit to 0.
- R2: A data field start is seen when `vid_data` carries a status byte right after the bytes FF, 00, 00 and bit 6 of that byte differs from bit 6 of the last status byte seen after such a prefix. Its parity is that bit 6 (0 = odd, 1 = even). A status byte whose bit 6 is unchanged is not an event.
- R3: A control field start is a cycle with `ctl_mark` high. Its parity is `ctl_field` (0 = odd, 1 = even).
- R4: If the control event comes N cycles before the data event, the result is +N. If the data event comes N cycles before the control event, the result is -N. If both come in the same cycle, the result is 0.
- R5: A result appears in `skew_value` together with a one-cycle `skew_valid` pulse, in the cycle after the clock edge that sampled the second event. In every other cycle `skew_value` holds its value.
- R6: If the two events carry different parity, no pulse is given, `skew_value` keeps its old value and the block returns to idle.
- R7: If the second event has not come by the time N reaches `max_cycles` (which must be at least 1), `timeout` pulses for one cycle, `skew_value` is kept and the block returns to idle. An event at exactly N = `max_cycles` is still measured.
- R8: While the block waits, a further event of the same kind as the first is ignored, so the count runs from the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_data | input | 8 | Video bytes from the slow path |
| ctl_mark | input | 1 | One-cycle control field marker from the fast path |
| ctl_field | input | 1 | Parity of the control marker |
| max_cycles | input | CW | Longest skew accepted before a timeout |
| skew_valid | output | 1 | One-cycle pulse when a new delay is published |
| skew_value | output | CW+1 | Signed delay in cycles; positive when data lags |
| timeout | output | 1 | One-cycle pulse when the second event did not come in time |

## Verification
The bench drives events in both orders and in the same cycle, so a design with the sign or the off-by-one count wrong would publish a value that is mirrored or shifted by one. It repeats status bytes with an unchanged field bit, which a design that does not track the field edge would turn into spurious starts. It sends events with opposite parity, where a design that does not check parity would overwrite the stored delay. It places the second event exactly at `max_cycles` and one cycle beyond it, which separates a correct window from one that times out too early or too late.

// File: rtl/field_skew_meter.sv
module field_skew_meter #(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           vid_data,
  input  logic                 ctl_mark,
  input  logic                 ctl_field,
  input  logic [CW-1:0]        max_cycles,
  output logic                 skew_valid,
  output logic signed [CW:0]   skew_value,
  output logic                 timeout
);

  typedef enum logic [1:0] {IDLE, WAIT_D, WAIT_C} st_t;

  st_t           st;
  logic [7:0]    h1, h2, h3;
  logic          f_last;
  logic          par0;
  logic [CW-1:0] cnt;

  wire trs       = (h3 == 8'hFF) && (h2 == 8'h00) && (h1 == 8'h00);
  wire d_par     = vid_data[6];
  wire d_ev      = trs && (d_par != f_last);
  wire other     = (st == WAIT_D) ? d_ev : (st == WAIT_C) ? ctl_mark : 1'b0;
  wire other_par = (st == WAIT_D) ? d_par : ctl_field;
  wire match     = (other_par == par0);
  wire signed [CW:0] mag = signed'({1'b0, cnt});

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      h1         <= '0;
      h2         <= '0;
      h3         <= '0;
      f_last     <= 1'b0;
      par0       <= 1'b0;
      cnt        <= '0;
      skew_valid <= 1'b0;
      skew_value <= '0;
      timeout    <= 1'b0;
    end else begin
      skew_valid   <= 1'b0;
      timeout      <= 1'b0;
      {h3, h2, h1} <= {h2, h1, vid_data};
      if (trs) f_last <= d_par;
      if (st == IDLE) begin
        cnt <= CW'(1);
        if (d_ev && ctl_mark) begin
          if (d_par == ctl_field) begin
            skew_valid <= 1'b1;
            skew_value <= '0;
          end
        end else if (ctl_mark) begin
          st   <= WAIT_D;
          par0 <= ctl_field;
        end else if (d_ev) begin
          st   <= WAIT_C;
          par0 <= d_par;
        end
      end else if (other) begin
        st <= IDLE;
        if (match) begin
          skew_valid <= 1'b1;
          skew_value <= (st == WAIT_D) ? mag : -mag;
        end
      end else if (cnt >= max_cycles) begin
        st      <= IDLE;
        timeout <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(skew_valid && timeout));
  a_r7_keep_value: assert property (@(posedge clk) disable iff (rst)
    timeout |-> $stable(skew_value));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
  a_r6_mismatch_silent: assert property (@(posedge clk) disable iff (rst)
    (st != IDLE && other && !match) |=> !skew_valid);
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !skew_valid |-> $stable(skew_value));
  a_r4_positive_when_data_lags: assert property (@(posedge clk) disable iff (rst)
    (st == WAIT_D && other && match) |=> (skew_value > 0));

endmodule

// File: tb/test_field_skew_meter.sv
module test_field_skew_meter;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] vid_data = 8'h10;
  logic ctl_mark = 1'b0, ctl_field = 1'b0;
  logic [CW-1:0] max_cycles = CW'(100);
  logic skew_valid, timeout;
  logic signed [CW:0] skew_value;

  field_skew_meter #(.CW(CW)) i_field_skew_meter (
    .clk(clk), .rst(rst), .vid_data(vid_data), .ctl_mark(ctl_mark),
    .ctl_field(ctl_field), .max_cycles(max_cycles),
    .skew_valid(skew_valid), .skew_value(skew_value), .timeout(timeout));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  string tag = "R1";

  // behavioural reference
  int hist[$] = '{0, 0, 0};
  int fl = 0, pend = 0, t0 = 0, p0 = 0, cyc = 0;
  int e_val = 0;
  bit e_vld = 0, e_tmo = 0;

  task automatic model();
    bit pre, dev;
    int n;
    cyc++;
    e_vld = 0; e_tmo = 0;
    if (rst) begin
      hist = '{0, 0, 0}; fl = 0; pend = 0; e_val = 0;
      return;
    end
    pre = (hist[0] == 8'hFF) && (hist[1] == 0) && (hist[2] == 0);
    dev = pre && (int'(vid_data[6]) != fl);
    if (pre) fl = vid_data[6];
    void'(hist.pop_front());
    hist.push_back(vid_data);
    if (pend == 0) begin
      if (dev && ctl_mark) begin
        if (vid_data[6] == ctl_field) begin e_vld = 1; e_val = 0; end
      end else if (ctl_mark) begin pend = 1; t0 = cyc; p0 = ctl_field; end
      else if (dev) begin pend = 2; t0 = cyc; p0 = vid_data[6]; end
    end else begin
      n = cyc - t0;
      if ((pend == 1 && dev) || (pend == 2 && ctl_mark)) begin
        if ((pend == 1 ? int'(vid_data[6]) : int'(ctl_field)) == p0) begin
          e_vld = 1; e_val = (pend == 1) ? n : -n;
        end
        pend = 0;
      end else if (n >= int'(max_cycles)) begin
        e_tmo = 1; pend = 0;
      end
    end
  endtask

  task automatic step(input logic [7:0] b, input logic m, input logic f);
    vid_data = b; ctl_mark = m; ctl_field = f;
    @(posedge clk);
    model();
    @(negedge clk);
    tests++;
    if (skew_valid !== e_vld || timeout !== e_tmo || int'(skew_value) != e_val) begin
      fails++;
      $display("FAIL %s cycle %0d: actual vld=%0b tmo=%0b val=%0d expected vld=%0b tmo=%0b val=%0d",
               tag, cyc, skew_valid, timeout, skew_value, e_vld, e_tmo, e_val);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(8'h10, 1'b0, 1'b0);
  endtask

  // timing code; control marker optionally on the status byte
  task automatic code(input logic [7:0] xy, input logic m, input logic f);
    step(8'hFF, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    step(xy, m, f);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);

    tag = "R4 control first";
    step(8'h10, 1'b1, 1'b1);
    idle(5);
    code(8'hE0, 1'b0, 1'b0);
    idle(3);

    tag = "R4 data first";
    code(8'hA0, 1'b0, 1'b0);
    idle(3);
    step(8'h10, 1'b1, 1'b0);
    idle(3);

    tag = "R4 same cycle";
    code(8'hE0, 1'b1, 1'b1);
    idle(3);

    tag = "R5 hold";
    idle(6);

    tag = "R2 unchanged field bit";
    code(8'hE0, 1'b0, 1'b0);
    code(8'hF0, 1'b0, 1'b0);
    idle(2);

    tag = "R6 parity mismatch";
    step(8'h10, 1'b1, 1'b1);
    idle(2);
    code(8'hA0, 1'b0, 1'b0);
    idle(3);

    tag = "R7 timeout";
    max_cycles = CW'(4);
    step(8'h10, 1'b1, 1'b1);
    idle(8);

    tag = "R7 exact window";
    step(8'h10, 1'b1, 1'b1);
    step(8'hFF, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    step(8'hE0, 1'b0, 1'b0);
    idle(3);

    tag = "R7 one beyond";
    code(8'hA0, 1'b0, 1'b0);
    idle(4);
    step(8'h10, 1'b1, 1'b0);
    idle(6);

    tag = "R8 repeated control";
    max_cycles = CW'(50);
    step(8'h10, 1'b1, 1'b1);
    idle(1);
    step(8'h10, 1'b1, 1'b1);
    code(8'hE0, 1'b0, 1'b0);
    idle(3);

    tag = "R3 R8 repeated data";
    code(8'hA0, 1'b0, 1'b0);
    code(8'hE0, 1'b0, 1'b0);
    step(8'h10, 1'b1, 1'b0);
    idle(3);

    tag = "R1 reset mid-run";
    step(8'h10, 1'b1, 1'b0);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule